// File: doc/BRIEF.md
# Checkpoint Flow and Instruction Count Guard

This block watches one application processor at run time. The program running there has been marked with checkpoints, one or two per basic block. At each checkpoint it sends a report that carries the checkpoint identifier and the current value of its instruction counter. The guard holds a table with one entry per checkpoint. Each entry names up to two permitted next checkpoints, and for each of them the exact number of instructions that must be retired on the way there. A report that names a checkpoint that is not a permitted successor, or that shows a different instruction count, starts a global abort interrupt.

The table is filled through a load port while the block is in its load phase. A pulse on the load-done input ends that phase. After it, the first report must name the configured entry checkpoint, and that report sets the counter baseline. The processor may stop reporting, for example after a hijacked return. To catch that case, the guard asks for the processor's instruction counter at a fixed interval. It aborts if the counter has moved past the largest count that any permitted successor allows. Once raised, the abort holds until reset.

Top module: `flow_count_guard`

## Requirements
- R1: While the block is in the load phase, load_we_i writes the entry addressed by load_id_i, and reports are ignored: abort_o stays low. A one-cycle pulse on load_done_i ends the load phase.
- R2: The first report after the load phase must carry entry_id_i, or abort_o is raised. The counter value of that report becomes the baseline.
- R3: Each later report must name a successor slot of the current checkpoint whose valid bit is set. Otherwise abort_o is raised. A slot with its valid bit clear never matches, whatever identifier it holds.
- R4: For the matching slot, the report's counter value minus the baseline must equal that slot's stored count exactly. Otherwise abort_o is raised. On success the reported checkpoint becomes current and its counter value becomes the new baseline.
- R5: The counter difference is taken modulo 2^IC_W, so a counter that wraps between two checkpoints is still checked correctly.
- R6: While the checker is running (after the entry report and before any abort), probe_req_o is high for one cycle in every PROBE_INTERVAL cycles. It is never high in the load phase, the entry wait or after an abort.
- R7: A probe response (probe_vld_i, probe_ic_i) is checked against the baseline. If the difference is larger than the largest count among the current checkpoint's valid slots, abort_o is raised. A difference equal to that count does not abort. A checkpoint with no valid slot is terminal and is exempt from this check.
- R8: abort_o is sticky. While it is high, reports, probes and loads change nothing, and probe_req_o stays low. Only rst_ni clears it.
- R9: abort_o rises on the first clock edge after the edge that sampled the offending report or probe response.
- R10: Writes on the load port after the load phase has ended are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| entry_id_i | input | ID_W | Checkpoint that the first report must name |
| load_we_i | input | 1 | Table write strobe |
| load_id_i | input | ID_W | Checkpoint entry to write |
| load_succ0_i | input | ID_W | Successor slot 0 identifier |
| load_succ0_vld_i | input | 1 | Slot 0 valid |
| load_cnt0_i | input | CNT_W | Instruction count towards slot 0 |
| load_succ1_i | input | ID_W | Successor slot 1 identifier |
| load_succ1_vld_i | input | 1 | Slot 1 valid |
| load_cnt1_i | input | CNT_W | Instruction count towards slot 1 |
| load_done_i | input | 1 | Ends the load phase |
| rep_vld_i | input | 1 | Checkpoint report strobe |
| rep_id_i | input | ID_W | Reported checkpoint |
| rep_ic_i | input | IC_W | Instruction counter at the checkpoint |
| probe_req_o | output | 1 | Request for the processor's counter |
| probe_vld_i | input | 1 | Probe response strobe |
| probe_ic_i | input | IC_W | Probed instruction counter |
| abort_o | output | 1 | Global abort interrupt |

## Verification
The assertions check, on every cycle, four properties: the abort stays high once raised, no abort can come out of the load phase, every abort rise follows a report or probe response, and a wrong entry report always aborts. They also check that probe requests are single-cycle pulses that stop after an abort. Only the bench scenarios can show the rest: the exact successor and count matching, modulo wraparound, the equal-versus-exceeded edge of the silence check, the terminal exemption, the probe rate and the rejected late table writes. These depend on table contents that the bench loads.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_ENTRY = 2'd1,
    ST_RUN   = 2'd2,
    ST_ABORT = 2'd3
  } phase_e;
endpackage

// File: rtl/fcg_table.sv
module fcg_table #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ID_W-1:0]  wr_id_i,
  input  logic [ID_W-1:0]  wr_succ0_i,
  input  logic             wr_v0_i,
  input  logic [CNT_W-1:0] wr_cnt0_i,
  input  logic [ID_W-1:0]  wr_succ1_i,
  input  logic             wr_v1_i,
  input  logic [CNT_W-1:0] wr_cnt1_i,
  input  logic [ID_W-1:0]  rd_id_i,
  output logic [ID_W-1:0]  succ0_o,
  output logic             v0_o,
  output logic [CNT_W-1:0] cnt0_o,
  output logic [ID_W-1:0]  succ1_o,
  output logic             v1_o,
  output logic [CNT_W-1:0] cnt1_o
);
  localparam int N = 1 << ID_W;

  logic [ID_W-1:0]  succ0_q [N];
  logic [ID_W-1:0]  succ1_q [N];
  logic [CNT_W-1:0] cnt0_q  [N];
  logic [CNT_W-1:0] cnt1_q  [N];
  logic [N-1:0]     v0_q, v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v0_q <= '0;
      v1_q <= '0;
      for (int i = 0; i < N; i++) begin
        succ0_q[i] <= '0;
        succ1_q[i] <= '0;
        cnt0_q[i]  <= '0;
        cnt1_q[i]  <= '0;
      end
    end else if (we_i) begin
      for (int i = 0; i < N; i++) begin
        if (wr_id_i == ID_W'(i)) begin
          succ0_q[i] <= wr_succ0_i;
          succ1_q[i] <= wr_succ1_i;
          cnt0_q[i]  <= wr_cnt0_i;
          cnt1_q[i]  <= wr_cnt1_i;
          v0_q[i]    <= wr_v0_i;
          v1_q[i]    <= wr_v1_i;
        end
      end
    end
  end

  assign succ0_o = succ0_q[rd_id_i];
  assign succ1_o = succ1_q[rd_id_i];
  assign cnt0_o  = cnt0_q[rd_id_i];
  assign cnt1_o  = cnt1_q[rd_id_i];
  assign v0_o    = v0_q[rd_id_i];
  assign v1_o    = v1_q[rd_id_i];
endmodule

// File: rtl/fcg_verdict.sv
module fcg_verdict #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 12,
  parameter int IC_W  = 32
) (
  input  logic [ID_W-1:0]  succ0_i,
  input  logic             v0_i,
  input  logic [CNT_W-1:0] cnt0_i,
  input  logic [ID_W-1:0]  succ1_i,
  input  logic             v1_i,
  input  logic [CNT_W-1:0] cnt1_i,
  input  logic [IC_W-1:0]  base_ic_i,
  input  logic [ID_W-1:0]  rep_id_i,
  input  logic [IC_W-1:0]  rep_ic_i,
  input  logic [IC_W-1:0]  probe_ic_i,
  output logic             step_ok_o,
  output logic             silent_o
);
  logic [IC_W-1:0] rep_diff, prb_diff, lim0, lim1, limit;
  logic            hit0, hit1;

  // modulo subtraction handles counter wrap
  assign rep_diff = rep_ic_i - base_ic_i;
  assign prb_diff = probe_ic_i - base_ic_i;

  assign hit0 = v0_i && (succ0_i == rep_id_i) && (rep_diff == IC_W'(cnt0_i));
  assign hit1 = v1_i && (succ1_i == rep_id_i) && (rep_diff == IC_W'(cnt1_i));
  assign step_ok_o = hit0 | hit1;

  assign lim0  = v0_i ? IC_W'(cnt0_i) : '0;
  assign lim1  = v1_i ? IC_W'(cnt1_i) : '0;
  assign limit = (lim0 > lim1) ? lim0 : lim1;

  // terminal checkpoint (no valid slot) is exempt
  assign silent_o = (v0_i | v1_i) && (prb_diff > limit);
endmodule

// File: rtl/fcg_prober.sv
module fcg_prober #(
  parameter int INTERVAL = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic req_o
);
  localparam int PW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [PW-1:0] LAST = PW'(INTERVAL - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i)            cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/flow_count_guard.sv
module flow_count_guard
  import fcg_pkg::*;
#(
  parameter int ID_W           = 4,
  parameter int CNT_W          = 12,
  parameter int IC_W           = 32,
  parameter int PROBE_INTERVAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  entry_id_i,
  input  logic             load_we_i,
  input  logic [ID_W-1:0]  load_id_i,
  input  logic [ID_W-1:0]  load_succ0_i,
  input  logic             load_succ0_vld_i,
  input  logic [CNT_W-1:0] load_cnt0_i,
  input  logic [ID_W-1:0]  load_succ1_i,
  input  logic             load_succ1_vld_i,
  input  logic [CNT_W-1:0] load_cnt1_i,
  input  logic             load_done_i,
  input  logic             rep_vld_i,
  input  logic [ID_W-1:0]  rep_id_i,
  input  logic [IC_W-1:0]  rep_ic_i,
  output logic             probe_req_o,
  input  logic             probe_vld_i,
  input  logic [IC_W-1:0]  probe_ic_i,
  output logic             abort_o
);
  phase_e          phase_q;
  logic [ID_W-1:0] cur_q;
  logic [IC_W-1:0] base_q;

  logic [ID_W-1:0]  t_succ0, t_succ1;
  logic [CNT_W-1:0] t_cnt0, t_cnt1;
  logic             t_v0, t_v1, step_ok, silent;

  fcg_table #(.ID_W(ID_W), .CNT_W(CNT_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (load_we_i && (phase_q == ST_LOAD)),
    .wr_id_i    (load_id_i),
    .wr_succ0_i (load_succ0_i),
    .wr_v0_i    (load_succ0_vld_i),
    .wr_cnt0_i  (load_cnt0_i),
    .wr_succ1_i (load_succ1_i),
    .wr_v1_i    (load_succ1_vld_i),
    .wr_cnt1_i  (load_cnt1_i),
    .rd_id_i    (cur_q),
    .succ0_o    (t_succ0),
    .v0_o       (t_v0),
    .cnt0_o     (t_cnt0),
    .succ1_o    (t_succ1),
    .v1_o       (t_v1),
    .cnt1_o     (t_cnt1)
  );

  fcg_verdict #(.ID_W(ID_W), .CNT_W(CNT_W), .IC_W(IC_W)) u_verdict (
    .succ0_i    (t_succ0),
    .v0_i       (t_v0),
    .cnt0_i     (t_cnt0),
    .succ1_i    (t_succ1),
    .v1_i       (t_v1),
    .cnt1_i     (t_cnt1),
    .base_ic_i  (base_q),
    .rep_id_i   (rep_id_i),
    .rep_ic_i   (rep_ic_i),
    .probe_ic_i (probe_ic_i),
    .step_ok_o  (step_ok),
    .silent_o   (silent)
  );

  fcg_prober #(.INTERVAL(PROBE_INTERVAL)) u_prober (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (phase_q == ST_RUN),
    .req_o  (probe_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_LOAD;
      cur_q   <= '0;
      base_q  <= '0;
    end else begin
      unique case (phase_q)
        ST_LOAD:  if (load_done_i) phase_q <= ST_ENTRY;
        ST_ENTRY: if (rep_vld_i) begin
          if (rep_id_i == entry_id_i) begin
            cur_q   <= rep_id_i;
            base_q  <= rep_ic_i;
            phase_q <= ST_RUN;
          end else begin
            phase_q <= ST_ABORT;
          end
        end
        ST_RUN: begin
          if (rep_vld_i) begin
            if (step_ok) begin
              cur_q  <= rep_id_i;
              base_q <= rep_ic_i;
            end else begin
              phase_q <= ST_ABORT;
            end
          end else if (probe_vld_i && silent) begin
            phase_q <= ST_ABORT;
          end
        end
        default: phase_q <= ST_ABORT;
      endcase
    end
  end

  assign abort_o = (phase_q == ST_ABORT);
endmodule

// File: rtl/fcg_sva.sv
module fcg_sva
  import fcg_pkg::*;
#(
  parameter int ID_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input phase_e          phase_i,
  input logic [ID_W-1:0] entry_id_i,
  input logic            rep_vld_i,
  input logic [ID_W-1:0] rep_id_i,
  input logic            probe_vld_i,
  input logic            probe_req_o,
  input logic            abort_o
);
  AST_ABORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> abort_o); // R8
  AST_LOAD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == ST_LOAD) |=> !abort_o); // R1
  AST_ENTRY_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == ST_ENTRY && rep_vld_i && rep_id_i != entry_id_i) |=> abort_o); // R2
  AST_ABORT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(rep_vld_i || probe_vld_i)); // R9
  AST_PROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_req_o |=> !probe_req_o); // R6
  AST_NO_PROBE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !probe_req_o); // R8
endmodule

bind flow_count_guard fcg_sva #(.ID_W(ID_W)) u_fcg_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_i     (phase_q),
  .entry_id_i  (entry_id_i),
  .rep_vld_i   (rep_vld_i),
  .rep_id_i    (rep_id_i),
  .probe_vld_i (probe_vld_i),
  .probe_req_o (probe_req_o),
  .abort_o     (abort_o)
);

// File: tb/flow_count_guard_bench.sv
`timescale 1ns/1ps
module flow_count_guard_bench;
  localparam int ID_W = 4, CNT_W = 12, IC_W = 32, PI = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ID_W-1:0]  entry_id = '0, ld_id = '0, ld_s0 = '0, ld_s1 = '0, rid = '0;
  logic             ld_we = 0, ld_v0 = 0, ld_v1 = 0, ld_done = 0, rvld = 0, pvld = 0;
  logic [CNT_W-1:0] ld_c0 = '0, ld_c1 = '0;
  logic [IC_W-1:0]  ric = '0, pic = '0;
  logic             preq, abort;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  flow_count_guard #(.ID_W(ID_W), .CNT_W(CNT_W), .IC_W(IC_W), .PROBE_INTERVAL(PI))
  u_flow_count_guard (
    .clk_i(clk), .rst_ni(rst_n), .entry_id_i(entry_id),
    .load_we_i(ld_we), .load_id_i(ld_id),
    .load_succ0_i(ld_s0), .load_succ0_vld_i(ld_v0), .load_cnt0_i(ld_c0),
    .load_succ1_i(ld_s1), .load_succ1_vld_i(ld_v1), .load_cnt1_i(ld_c1),
    .load_done_i(ld_done), .rep_vld_i(rvld), .rep_id_i(rid), .rep_ic_i(ric),
    .probe_req_o(preq), .probe_vld_i(pvld), .probe_ic_i(pic), .abort_o(abort)
  );

  typedef struct packed { logic [3:0] id; logic [31:0] ic; } vec_t;
  // legal walk: 0->1->3->0->2->3->0->2->4
  localparam vec_t PATH [0:8] = '{
    '{4'd0, 32'd100}, '{4'd1, 32'd105}, '{4'd3, 32'd109}, '{4'd0, 32'd111},
    '{4'd2, 32'd120}, '{4'd3, 32'd127}, '{4'd0, 32'd129}, '{4'd2, 32'd138},
    '{4'd4, 32'd141}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ld_we = 0; ld_done = 0; rvld = 0; pvld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic load_one(int id, int s0, bit v0, int c0, int s1, bit v1, int c1);
    ld_we = 1; ld_id = ID_W'(id);
    ld_s0 = ID_W'(s0); ld_v0 = v0; ld_c0 = CNT_W'(c0);
    ld_s1 = ID_W'(s1); ld_v1 = v1; ld_c1 = CNT_W'(c1);
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic finish_load();
    ld_done = 1;
    @(negedge clk);
    ld_done = 0;
  endtask

  task automatic load_prog();
    load_one(0, 1, 1, 5, 2, 1, 9);
    load_one(1, 3, 1, 4, 5, 0, 1);   // slot 1 holds id 5 but invalid
    load_one(2, 3, 1, 7, 4, 1, 3);
    load_one(3, 0, 1, 2, 0, 0, 0);
    load_one(4, 0, 0, 0, 0, 0, 0);   // terminal
    finish_load();
  endtask

  task automatic report(int id, logic [31:0] ic);
    rvld = 1; rid = ID_W'(id); ric = ic;
    @(negedge clk);
    rvld = 0;
  endtask

  task automatic probe(logic [31:0] ic);
    pvld = 1; pic = ic;
    @(negedge clk);
    pvld = 0;
  endtask

  task automatic count_req(int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (preq) n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    chk("reset abort", abort, 0);
    chk("reset probe_req", preq, 0);

    // vector walk: R2 R3 R4
    load_prog();
    for (int i = 0; i < 9; i++) begin
      report(PATH[i].id, PATH[i].ic);
      chk("R3/R4 legal path", abort, 0);
    end

    // R1: reports ignored during load
    do_reset();
    load_one(0, 1, 1, 5, 2, 1, 9);
    report(7, 5);
    chk("R1 report in load", abort, 0);
    count_req(40, n);
    chk("R6 no probe in load", n, 0);
    load_one(1, 3, 1, 4, 5, 0, 1);
    finish_load();
    report(0, 100);
    report(1, 105);
    chk("R1 loaded entries used", abort, 0);

    // R2: wrong entry
    do_reset(); load_prog();
    report(1, 100);
    chk("R2 wrong entry", abort, 1);

    // R3: illegal successor, R9 timing
    do_reset(); load_prog();
    report(0, 100);
    chk("R9 no early abort", abort, 0);
    report(3, 105);
    chk("R3 R9 illegal successor", abort, 1);

    // R3: invalid slot never matches
    do_reset(); load_prog();
    report(0, 100); report(1, 105);
    report(5, 106);
    chk("R3 invalid slot", abort, 1);

    // R4: count mismatch
    do_reset(); load_prog();
    report(0, 100);
    report(1, 106);
    chk("R4 count mismatch", abort, 1);

    // R5: wraparound
    do_reset(); load_prog();
    report(0, 32'hFFFF_FFFE);
    report(1, 32'd3);
    chk("R5 wrap ok", abort, 0);
    report(3, 32'd8);
    chk("R5 after wrap mismatch", abort, 1);

    // R6: probe rate while running; R7 silence
    do_reset(); load_prog();
    report(0, 100);
    count_req(64, n);
    chk("R6 probe rate", n, 64 / PI);
    probe(109);
    chk("R7 at limit", abort, 0);
    probe(110);
    chk("R7 silence", abort, 1);

    // R8: sticky abort
    report(0, 100);
    report(1, 105);
    chk("R8 sticky", abort, 1);
    count_req(40, n);
    chk("R8 no probe after abort", n, 0);
    do_reset();
    chk("R8 reset clears", abort, 0);

    // R7 terminal exemption
    load_prog();
    report(0, 100); report(2, 109); report(4, 112);
    probe(5000);
    chk("R7 terminal exempt", abort, 0);

    // R10: late loads ignored
    do_reset(); load_prog();
    load_one(0, 1, 1, 6, 2, 1, 9);
    report(0, 100);
    report(1, 105);
    chk("R10 late load ignored", abort, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule